// File: doc/BRIEF.md
# Background Write-Back Flush Scheduler

This block sits beside a write-allocating cache that fronts a slow, write-limited backing memory. The cache keeps a spare way free in every set by invalidating blocks before a set fills. It hands the address of each invalidated block, together with the set and way it occupied, to this scheduler. The scheduler holds these entries and writes them back to the slow memory during cycles when no demand request is using either memory.

Entries come in through one enqueue port. An urgency flag on that port routes each entry to one of two FIFOs. The cache raises the flag when the set has no free way left, and such entries go to the urgent FIFO. All other entries go to the normal FIFO. The urgent FIFO always wins over the normal FIFO. Only one write-back is in flight at a time. When the slow-memory side reports completion, the scheduler returns the set and way to the cache so that the way can be marked free.

Top module: `fsched_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `flush_req` and `free_valid` are low, and both FIFOs report empty (`q0_empty`=1, `q1_empty`=1, `q0_full`=0, `q1_full`=0).
- R2: An accepted enqueue with `enq_urgent`=1 goes to the urgent FIFO (queue 0). With `enq_urgent`=0 it goes to the normal FIFO (queue 1). The full and empty flags of each FIFO follow its occupancy one cycle after the accepting edge.
- R3: `enq_ready` is the inverse of the full flag of the FIFO that `enq_urgent` selects. An enqueue offered while `enq_ready` is low is dropped and does not change any FIFO.
- R4: A flush is taken from the normal FIFO only if the urgent FIFO was empty at the deciding edge. `flush_urgent` is 1 when the flush came from the urgent FIFO.
- R5: Within each FIFO, entries are flushed in the order they were accepted. `flush_addr` carries the accepted `enq_addr`.
- R6: A flush is started only at an edge where `cache_busy`=0 and `slow_busy`=0, no flush is outstanding, and at least one FIFO is non-empty.
- R7: After a flush starts, no further flush starts until `flush_done` has been sampled high.
- R8: The cycle after `flush_done` is sampled high while a flush is outstanding, `free_valid` is high for exactly one cycle. In that cycle `free_set` and `free_way` equal the set and way enqueued with the completed entry.
- R9: `flush_done` sampled while no flush is outstanding is ignored: `free_valid` stays low.
- R10: `flush_req` is a single-cycle pulse in the cycle after the deciding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue request |
| enq_urgent | input | 1 | 1: set has no free way, route to urgent FIFO |
| enq_addr | input | ADDR_W | Physical address of the invalidated block |
| enq_set | input | SET_W | Set index of the block |
| enq_way | input | WAY_W | Way index of the block |
| enq_ready | output | 1 | Selected FIFO can accept |
| cache_busy | input | 1 | Cache memory serving demand traffic |
| slow_busy | input | 1 | Slow memory serving demand traffic |
| flush_req | output | 1 | One-cycle write-back start pulse |
| flush_urgent | output | 1 | Current flush came from the urgent FIFO |
| flush_addr | output | ADDR_W | Address of the block to write back |
| flush_done | input | 1 | Write-back of the outstanding block finished |
| free_valid | output | 1 | One-cycle pulse: way may be freed |
| free_set | output | SET_W | Set of the freed way |
| free_way | output | WAY_W | Way to free |
| q0_full | output | 1 | Urgent FIFO full |
| q0_empty | output | 1 | Urgent FIFO empty |
| q1_full | output | 1 | Normal FIFO full |
| q1_empty | output | 1 | Normal FIFO empty |

## Verification
The hardest case to reach is an urgent entry that arrives while a normal backlog is already queued. It must then overtake that backlog at the next idle window, while a flush is still outstanding or a busy signal is toggling. The stimulus first holds the slow memory busy so that both FIFOs fill up to backpressure. It then opens idle windows at random, with completions at random delays and spurious completions mixed in. A behavioural queue model is compared against the outputs on every cycle.

// File: rtl/fsched_pkg.sv
package fsched_pkg;
  typedef enum logic [0:0] {
    FS_IDLE = 1'b0,
    FS_WAIT = 1'b1
  } fs_state_e;
endpackage

// File: rtl/fsched_fifo.sv
module fsched_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_en) wp_d = (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
    if (rd_en) rp_d = (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
    unique case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wp_q] <= wr_data;
  end

  assign head    = mem_q[rp_q];
  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);

  // R3: a push never lands on a full FIFO
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full_o);
  // R5: a pop never reads an empty FIFO
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty_o);
endmodule

// File: rtl/fsched_arb.sv
module fsched_arb (
  input  logic grant_en,
  input  logic q0_empty,
  input  logic q1_empty,
  output logic pop0,
  output logic pop1
);
  always_comb begin
    pop0 = grant_en && !q0_empty;
    pop1 = grant_en && q0_empty && !q1_empty;
  end
endmodule

// File: rtl/fsched_top.sv
module fsched_top #(
  parameter int ADDR_W   = 32,
  parameter int SET_W    = 6,
  parameter int WAY_W    = 2,
  parameter int Q0_DEPTH = 4,
  parameter int Q1_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic              enq_urgent,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [SET_W-1:0]  enq_set,
  input  logic [WAY_W-1:0]  enq_way,
  output logic              enq_ready,
  input  logic              cache_busy,
  input  logic              slow_busy,
  output logic              flush_req,
  output logic              flush_urgent,
  output logic [ADDR_W-1:0] flush_addr,
  input  logic              flush_done,
  output logic              free_valid,
  output logic [SET_W-1:0]  free_set,
  output logic [WAY_W-1:0]  free_way,
  output logic              q0_full,
  output logic              q0_empty,
  output logic              q1_full,
  output logic              q1_empty
);
  import fsched_pkg::*;

  localparam int ENT_W = ADDR_W + SET_W + WAY_W;

  logic [ENT_W-1:0] enq_ent, q0_head, q1_head, sel_ent;
  logic push0, push1, pop0, pop1, grant_en, idle_win;

  fs_state_e        state_q, state_d;
  logic             req_q, req_d, urg_q, urg_d, free_q, free_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SET_W-1:0]  set_q, set_d;
  logic [WAY_W-1:0]  way_q, way_d;

  assign enq_ent   = {enq_addr, enq_set, enq_way};
  assign enq_ready = enq_urgent ? !q0_full : !q1_full;
  assign push0     = enq_valid && enq_urgent && !q0_full;
  assign push1     = enq_valid && !enq_urgent && !q1_full;
  assign idle_win  = !cache_busy && !slow_busy;
  assign grant_en  = (state_q == FS_IDLE) && idle_win;

  fsched_fifo #(.WIDTH(ENT_W), .DEPTH(Q0_DEPTH)) u_q0 (
    .clk(clk), .rst_n(rst_n), .wr_en(push0), .wr_data(enq_ent),
    .rd_en(pop0), .head(q0_head), .full_o(q0_full), .empty_o(q0_empty));

  fsched_fifo #(.WIDTH(ENT_W), .DEPTH(Q1_DEPTH)) u_q1 (
    .clk(clk), .rst_n(rst_n), .wr_en(push1), .wr_data(enq_ent),
    .rd_en(pop1), .head(q1_head), .full_o(q1_full), .empty_o(q1_empty));

  fsched_arb u_arb (
    .grant_en(grant_en), .q0_empty(q0_empty), .q1_empty(q1_empty),
    .pop0(pop0), .pop1(pop1));

  assign sel_ent = pop0 ? q0_head : q1_head;

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    free_d  = 1'b0;
    urg_d   = urg_q;
    addr_d  = addr_q;
    set_d   = set_q;
    way_d   = way_q;
    unique case (state_q)
      FS_IDLE: begin
        if (pop0 || pop1) begin
          state_d = FS_WAIT;
          req_d   = 1'b1;
          urg_d   = pop0;
          {addr_d, set_d, way_d} = sel_ent;
        end
      end
      FS_WAIT: begin
        if (flush_done) begin
          state_d = FS_IDLE;
          free_d  = 1'b1;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      req_q   <= 1'b0;
      free_q  <= 1'b0;
      urg_q   <= 1'b0;
      addr_q  <= '0;
      set_q   <= '0;
      way_q   <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      free_q  <= free_d;
      urg_q   <= urg_d;
      addr_q  <= addr_d;
      set_q   <= set_d;
      way_q   <= way_d;
    end
  end

  assign flush_req    = req_q;
  assign flush_urgent = urg_q;
  assign flush_addr   = addr_q;
  assign free_valid   = free_q;
  assign free_set     = set_q;
  assign free_way     = way_q;

  // R6: flushes start only in a window with both memories idle
  assert_idle_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(!cache_busy && !slow_busy));
  // R7: while waiting without completion no new flush appears
  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_WAIT && !flush_done) |=> !flush_req);
  // R10: start is a single-cycle pulse
  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);
  // R4: normal entries only when the urgent FIFO was empty
  assert_strict_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_urgent) |-> $past(q0_empty));
  // R8: a freed way always follows a completion
  assert_free_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> $past(flush_done));
  // R9: completion with nothing outstanding frees nothing
  assert_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_IDLE && flush_done) |=> !free_valid);
endmodule

// File: tb/tb_fsched_top.sv
`timescale 1ns/1ps
module tb_fsched_top;
  localparam int ADDR_W = 32;
  localparam int SET_W  = 6;
  localparam int WAY_W  = 2;
  localparam int D0     = 4;
  localparam int D1     = 8;
  localparam int ENT_W  = ADDR_W + SET_W + WAY_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 0, enq_urgent = 0, cache_busy = 0, slow_busy = 0, flush_done = 0;
  logic [ADDR_W-1:0] enq_addr = '0;
  logic [SET_W-1:0]  enq_set = '0;
  logic [WAY_W-1:0]  enq_way = '0;
  logic enq_ready, flush_req, flush_urgent, free_valid;
  logic q0_full, q0_empty, q1_full, q1_empty;
  logic [ADDR_W-1:0] flush_addr;
  logic [SET_W-1:0]  free_set;
  logic [WAY_W-1:0]  free_way;

  always #2.5 clk = ~clk;

  fsched_top #(.ADDR_W(ADDR_W), .SET_W(SET_W), .WAY_W(WAY_W),
               .Q0_DEPTH(D0), .Q1_DEPTH(D1)) dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_urgent(enq_urgent),
    .enq_addr(enq_addr), .enq_set(enq_set), .enq_way(enq_way), .enq_ready(enq_ready),
    .cache_busy(cache_busy), .slow_busy(slow_busy), .flush_req(flush_req),
    .flush_urgent(flush_urgent), .flush_addr(flush_addr), .flush_done(flush_done),
    .free_valid(free_valid), .free_set(free_set), .free_way(free_way),
    .q0_full(q0_full), .q0_empty(q0_empty), .q1_full(q1_full), .q1_empty(q1_empty));

  // behavioural reference model
  logic [ENT_W-1:0] mq0[$], mq1[$];
  bit m_wait, m_req, m_urg, m_free;
  logic [ENT_W-1:0] m_ent;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq0.delete(); mq1.delete();
      m_wait = 0; m_req = 0; m_urg = 0; m_free = 0;
    end else begin
      bit was_wait;
      bit acc0, acc1;
      was_wait = m_wait;
      acc0 = enq_valid && enq_urgent && (mq0.size() < D0);
      acc1 = enq_valid && !enq_urgent && (mq1.size() < D1);
      m_req = 0;
      m_free = 0;
      if (!was_wait && !cache_busy && !slow_busy && (mq0.size() + mq1.size() > 0)) begin
        if (mq0.size() > 0) begin m_ent = mq0.pop_front(); m_urg = 1; end
        else begin m_ent = mq1.pop_front(); m_urg = 0; end
        m_req = 1;
        m_wait = 1;
      end
      if (was_wait && flush_done) begin
        m_free = 1;
        m_wait = 0;
      end
      if (acc0) mq0.push_back({enq_addr, enq_set, enq_way});
      if (acc1) mq1.push_back({enq_addr, enq_set, enq_way});
    end
  end

  int n_checks = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit exp_ready;
    string t_req, t_free;
    exp_ready = enq_urgent ? (mq0.size() < D0) : (mq1.size() < D1);
    chk("R3 enq_ready", 64'(enq_ready), 64'(exp_ready));
    chk("R2 q0_empty", 64'(q0_empty), 64'(mq0.size() == 0));
    chk("R2 q1_empty", 64'(q1_empty), 64'(mq1.size() == 0));
    chk("R3 q0_full", 64'(q0_full), 64'(mq0.size() == D0));
    chk("R3 q1_full", 64'(q1_full), 64'(mq1.size() == D1));
    t_req = m_req ? "R10 flush_req" : (m_wait ? "R7 flush_req" : "R6 flush_req");
    chk(t_req, 64'(flush_req), 64'(m_req));
    if (m_req) begin
      chk("R4 flush_urgent", 64'(flush_urgent), 64'(m_urg));
      chk("R5 flush_addr", 64'(flush_addr), 64'(m_ent[ENT_W-1 -: ADDR_W]));
    end
    t_free = m_free ? "R8 free_valid" : "R9 free_valid";
    chk(t_free, 64'(free_valid), 64'(m_free));
    if (m_free) begin
      chk("R8 free_set", 64'(free_set), 64'(m_ent[WAY_W +: SET_W]));
      chk("R8 free_way", 64'(free_way), 64'(m_ent[WAY_W-1:0]));
    end
  endtask

  task automatic drive(input int p_enq, input int p_urg, input int p_busy, input int p_done);
    enq_valid  = ($urandom % 100) < p_enq;
    enq_urgent = ($urandom % 100) < p_urg;
    enq_addr   = $urandom;
    enq_set    = SET_W'($urandom);
    enq_way    = WAY_W'($urandom);
    cache_busy = ($urandom % 100) < p_busy;
    slow_busy  = ($urandom % 100) < p_busy;
    flush_done = ($urandom % 100) < p_done;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 flush_req", 64'(flush_req), 64'd0);
    chk("R1 free_valid", 64'(free_valid), 64'd0);
    chk("R1 q0_empty", 64'(q0_empty), 64'd1);
    chk("R1 q1_empty", 64'(q1_empty), 64'd1);
    chk("R1 q0_full", 64'(q0_full), 64'd0);
    chk("R1 q1_full", 64'(q1_full), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flush_req after release", 64'(flush_req), 64'd0);
    // phase A: slow memory busy, FIFOs fill to backpressure (R2, R3)
    for (int i = 0; i < 40; i++) begin
      drive(90, 35, 0, 20);
      slow_busy = 1'b1;
      @(negedge clk);
      compare_all();
    end
    // phase B: random idle windows, mixed completions (R4..R10)
    for (int i = 0; i < 4000; i++) begin
      drive((i % 400 < 200) ? 60 : 15, 30, 40, 30);
      @(negedge clk);
      compare_all();
    end
    // phase C: drain with all traffic idle
    for (int i = 0; i < 200; i++) begin
      drive(0, 0, 0, 50);
      @(negedge clk);
      compare_all();
    end
    done_flag = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule